// File: doc/BRIEF.md
# Unpacked Floating-Point Divider

This block divides one unpacked floating-point operand (x) by another (y). Each operand arrives already split into a class code, a sign bit, a signed two's-complement exponent and a mantissa. The mantissa is an integer of `MANT_W` bits whose top bit is the leading one, so a normal mantissa `M` stands for `M / 2^(MANT_W-1)` in [1.0, 2.0). The low bits include the guard and round positions. Packing, unpacking and rounding belong to neighbouring stages.

A one-cycle `start` pulse launches an operation. When either operand is zero, infinite or a NaN, the block settles the result in one cycle. When both operands are normal, it pre-normalizes by comparing the mantissas. It then runs a restoring divider that retires one quotient bit per clock, most significant bit first. The result comes out with a sticky bit that records a nonzero final remainder. The invalid and divide-by-zero flags travel with the `done` pulse.

Top module: `fdiv_unit`

## Requirements
- R1: For normal x and y, let X and Y be the mantissa integers. If X >= Y, `r_mant` = floor(X·2^(MANT_W-1) / Y). Otherwise `r_mant` = floor(X·2^MANT_W / Y). `r_cls` is normal (code 1), and bit MANT_W-1 of `r_mant` is set.
- R2: For normal operands, `r_exp` = x_exp − y_exp when X >= Y, and x_exp − y_exp − 1 when X < Y. The arithmetic is modulo 2^EXP_W.
- R3: For normal operands, `r_sticky` is 1 exactly when the division in R1 leaves a nonzero remainder. Every special-case result has `r_sticky` = 0.
- R4: For every result that is not a NaN, `r_sign` = x_sign XOR y_sign.
- R5: For normal operands, `busy` is high for exactly MANT_W cycles starting the cycle after `start` is accepted. `done` is high in the single cycle that follows them. `busy` and `done` are never high together.
- R6: Class codes are 0 zero, 1 normal, 2 infinity, 3 quiet NaN, 4 signalling NaN. If either operand is a NaN, the block returns one operand unchanged (class, sign, exponent, mantissa). It returns y when y is a NaN, unless x is a signalling NaN and y is a quiet NaN. In every other NaN case it returns x. No flag is raised.
- R7: Infinity/infinity and zero/zero each give a new quiet NaN with sign 0, exponent 0 and an all-ones mantissa, and raise `flag_nv`.
- R8: Infinity divided by a normal or by zero gives infinity. Zero divided by infinity or by a normal gives zero. A normal divided by infinity gives zero. Each of these results has exponent 0, mantissa 0 and no flag.
- R9: A normal divided by zero gives infinity (exponent 0, mantissa 0) and raises `flag_dz` without `flag_nv`.
- R10: Any operand pair with a zero, infinite or NaN operand completes with `done` high in the cycle right after `start` is accepted, and `busy` stays low.
- R11: A `start` pulse while `busy` is high is ignored: no extra `done` pulse occurs, and the result in flight is not altered.
- R12: `flag_nv` and `flag_dz` are low in every cycle where `done` is low, including after reset, when `busy` and `done` are also low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, accepted when `busy` is low |
| x_cls | input | 3 | Dividend class code |
| x_sign | input | 1 | Dividend sign |
| x_exp | input | EXP_W | Dividend exponent, two's complement |
| x_mant | input | MANT_W | Dividend mantissa, leading one at the top |
| y_cls | input | 3 | Divisor class code |
| y_sign | input | 1 | Divisor sign |
| y_exp | input | EXP_W | Divisor exponent, two's complement |
| y_mant | input | MANT_W | Divisor mantissa, leading one at the top |
| busy | output | 1 | Iterative division in progress |
| done | output | 1 | One-cycle completion strobe |
| r_cls | output | 3 | Result class code |
| r_sign | output | 1 | Result sign |
| r_exp | output | EXP_W | Result exponent |
| r_mant | output | MANT_W | Result quotient mantissa |
| r_sticky | output | 1 | Nonzero bits lie below the last quotient bit |
| flag_nv | output | 1 | Invalid operation, valid with `done` |
| flag_dz | output | 1 | Division by zero, valid with `done` |

## Verification
The iterative path is driven with equal mantissas, a dividend below the divisor, and the all-ones and minimum mantissas in both orders. This covers the pre-normalization branch, the exponent decrement and both extremes of the quotient range. Exact quotients are separated from inexact ones, such as division by 1.5, so that a stuck or inverted sticky bit shows up. A stream of pseudo-random normal pairs with mixed signs and exponents then exercises the subtract-or-keep decision in every bit position. All twenty-five class pairs are swept to cover the NaN selection order, the invalid and divide-by-zero cases, and the one-cycle latency. A start pulse injected mid-division shows that the running result is not disturbed.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    // Operand and result class encoding shared by all stages of the divider.
    typedef enum logic [2:0] {
        FC_ZERO = 3'd0,
        FC_NORM = 3'd1,
        FC_INF  = 3'd2,
        FC_QNAN = 3'd3,
        FC_SNAN = 3'd4
    } fclass_e;

endpackage

// File: rtl/fdiv_special.sv
module fdiv_special
    import fdiv_pkg::*;
#(
    parameter int EXP_W  = 12,
    parameter int MANT_W = 26
) (
    input  logic [2:0]        x_cls,
    input  logic              x_sign,
    input  logic [EXP_W-1:0]  x_exp,
    input  logic [MANT_W-1:0] x_mant,
    input  logic [2:0]        y_cls,
    input  logic              y_sign,
    input  logic [EXP_W-1:0]  y_exp,
    input  logic [MANT_W-1:0] y_mant,
    output logic              hit,
    output logic [2:0]        res_cls,
    output logic              res_sign,
    output logic [EXP_W-1:0]  res_exp,
    output logic [MANT_W-1:0] res_mant,
    output logic              res_nv,
    output logic              res_dz
);

    logic x_qnan, x_snan, y_qnan, y_snan, x_nan, y_nan;
    logic x_inf, x_zero, y_inf, y_zero;
    logic sgn_xor;

    assign x_qnan  = (x_cls == FC_QNAN);
    assign x_snan  = (x_cls == FC_SNAN);
    assign y_qnan  = (y_cls == FC_QNAN);
    assign y_snan  = (y_cls == FC_SNAN);
    assign x_nan   = x_qnan | x_snan;
    assign y_nan   = y_qnan | y_snan;
    assign x_inf   = (x_cls == FC_INF);
    assign x_zero  = (x_cls == FC_ZERO);
    assign y_inf   = (y_cls == FC_INF);
    assign y_zero  = (y_cls == FC_ZERO);
    assign sgn_xor = x_sign ^ y_sign;

    always_comb begin
        hit      = 1'b1;
        res_cls  = x_cls;
        res_sign = x_sign;
        res_exp  = x_exp;
        res_mant = x_mant;
        res_nv   = 1'b0;
        res_dz   = 1'b0;
        if (x_nan || y_nan) begin
            // a lone signalling NaN wins; otherwise the divisor NaN wins
            if (y_nan && !(x_snan && y_qnan)) begin
                res_cls  = y_cls;
                res_sign = y_sign;
                res_exp  = y_exp;
                res_mant = y_mant;
            end
        end else if ((x_inf && y_inf) || (x_zero && y_zero)) begin
            res_cls  = FC_QNAN;
            res_sign = 1'b0;
            res_exp  = '0;
            res_mant = '1;
            res_nv   = 1'b1;
        end else if (x_inf || x_zero) begin
            res_cls  = x_cls;
            res_sign = sgn_xor;
            res_exp  = '0;
            res_mant = '0;
        end else if (y_inf) begin
            res_cls  = FC_ZERO;
            res_sign = sgn_xor;
            res_exp  = '0;
            res_mant = '0;
        end else if (y_zero) begin
            res_cls  = FC_INF;
            res_sign = sgn_xor;
            res_exp  = '0;
            res_mant = '0;
            res_dz   = 1'b1;
        end else begin
            hit = 1'b0;
        end
    end

endmodule

// File: rtl/fdiv_step.sv
module fdiv_step #(
    parameter int MANT_W = 26
) (
    input  logic [MANT_W:0]   rem,
    input  logic [MANT_W-1:0] div,
    output logic              qbit,
    output logic [MANT_W:0]   rem_nxt
);

    localparam int DIFF_W = MANT_W + 2;

    logic [DIFF_W-1:0] diff;
    logic [MANT_W:0]   kept;

    // one extra bit so the sign of the trial difference is never lost
    assign diff    = {1'b0, rem} - {2'b00, div};
    assign qbit    = ~diff[DIFF_W-1];
    assign kept    = qbit ? diff[MANT_W:0] : rem;
    // kept is always below the divisor, so its top bit is zero
    assign rem_nxt = {kept[MANT_W-1:0], 1'b0};

endmodule

// File: rtl/fdiv_unit.sv
module fdiv_unit
    import fdiv_pkg::*;
#(
    parameter int EXP_W  = 12,
    parameter int MANT_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        x_cls,
    input  logic              x_sign,
    input  logic [EXP_W-1:0]  x_exp,
    input  logic [MANT_W-1:0] x_mant,
    input  logic [2:0]        y_cls,
    input  logic              y_sign,
    input  logic [EXP_W-1:0]  y_exp,
    input  logic [MANT_W-1:0] y_mant,
    output logic              busy,
    output logic              done,
    output logic [2:0]        r_cls,
    output logic              r_sign,
    output logic [EXP_W-1:0]  r_exp,
    output logic [MANT_W-1:0] r_mant,
    output logic              r_sticky,
    output logic              flag_nv,
    output logic              flag_dz
);

    localparam int CNT_W = $clog2(MANT_W + 1);
    localparam int REM_W = MANT_W + 1;

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [CNT_W-1:0]  cnt;
        logic [REM_W-1:0]  rem;
        logic [MANT_W-1:0] div;
        logic [MANT_W-1:0] quo;
        logic [EXP_W-1:0]  exp;
        logic              sign;
        logic [2:0]        r_cls;
        logic              r_sign;
        logic [EXP_W-1:0]  r_exp;
        logic [MANT_W-1:0] r_mant;
        logic              r_sticky;
        logic              nv;
        logic              dz;
    } state_t;

    state_t st_d, st_q;

    logic              sp_hit;
    logic [2:0]        sp_cls;
    logic              sp_sign;
    logic [EXP_W-1:0]  sp_exp;
    logic [MANT_W-1:0] sp_mant;
    logic              sp_nv;
    logic              sp_dz;
    logic              step_bit;
    logic [REM_W-1:0]  step_rem;
    logic [MANT_W-1:0] quo_next;
    logic              x_lt_y;

    fdiv_special #(
        .EXP_W  (EXP_W),
        .MANT_W (MANT_W)
    ) u_special (
        .x_cls    (x_cls),
        .x_sign   (x_sign),
        .x_exp    (x_exp),
        .x_mant   (x_mant),
        .y_cls    (y_cls),
        .y_sign   (y_sign),
        .y_exp    (y_exp),
        .y_mant   (y_mant),
        .hit      (sp_hit),
        .res_cls  (sp_cls),
        .res_sign (sp_sign),
        .res_exp  (sp_exp),
        .res_mant (sp_mant),
        .res_nv   (sp_nv),
        .res_dz   (sp_dz)
    );

    fdiv_step #(
        .MANT_W (MANT_W)
    ) u_step (
        .rem     (st_q.rem),
        .div     (st_q.div),
        .qbit    (step_bit),
        .rem_nxt (step_rem)
    );

    assign x_lt_y   = (x_mant < y_mant);
    assign quo_next = {st_q.quo[MANT_W-2:0], step_bit};

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.nv   = 1'b0;
        st_d.dz   = 1'b0;
        if (st_q.busy) begin
            st_d.rem = step_rem;
            st_d.quo = quo_next;
            st_d.cnt = st_q.cnt - CNT_W'(1);
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.busy     = 1'b0;
                st_d.done     = 1'b1;
                st_d.r_cls    = FC_NORM;
                st_d.r_sign   = st_q.sign;
                st_d.r_exp    = st_q.exp;
                st_d.r_mant   = quo_next;
                st_d.r_sticky = |step_rem;
            end
        end else if (start) begin
            if (sp_hit) begin
                st_d.done     = 1'b1;
                st_d.r_cls    = sp_cls;
                st_d.r_sign   = sp_sign;
                st_d.r_exp    = sp_exp;
                st_d.r_mant   = sp_mant;
                st_d.r_sticky = 1'b0;
                st_d.nv       = sp_nv;
                st_d.dz       = sp_dz;
            end else begin
                st_d.busy = 1'b1;
                st_d.cnt  = CNT_W'(MANT_W);
                st_d.div  = y_mant;
                st_d.quo  = '0;
                st_d.sign = x_sign ^ y_sign;
                // pre-normalize: a smaller dividend is doubled up front
                if (x_lt_y) begin
                    st_d.rem = {x_mant, 1'b0};
                    st_d.exp = x_exp - y_exp - EXP_W'(1);
                end else begin
                    st_d.rem = {1'b0, x_mant};
                    st_d.exp = x_exp - y_exp;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = st_q.busy;
    assign done     = st_q.done;
    assign r_cls    = st_q.r_cls;
    assign r_sign   = st_q.r_sign;
    assign r_exp    = st_q.r_exp;
    assign r_mant   = st_q.r_mant;
    assign r_sticky = st_q.r_sticky;
    assign flag_nv  = st_q.nv;
    assign flag_dz  = st_q.dz;

endmodule

module fdiv_chk
    import fdiv_pkg::*;
#(
    parameter int MANT_W = 26
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [2:0]        r_cls,
    input logic [MANT_W-1:0] r_mant,
    input logic              r_sticky,
    input logic              flag_nv,
    input logic              flag_dz
);

    localparam int RUN_W = $clog2(MANT_W + 2);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (busy) begin
            run_q <= run_q + RUN_W'(1);
        end else begin
            run_q <= '0;
        end
    end

    // R5
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R5
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == RUN_W'(MANT_W)) && done);

    // R12
    flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> !flag_nv && !flag_dz);

    // R9
    dz_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_dz |-> (r_cls == FC_INF) && !flag_nv);

    // R7
    nv_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_nv |-> (r_cls == FC_QNAN) && !r_sticky);

    // R1
    norm_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && r_cls == FC_NORM) |-> r_mant[MANT_W-1]);

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    // R10
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) || $past(start)));

endmodule

bind fdiv_unit fdiv_chk #(.MANT_W(MANT_W)) u_fdiv_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .r_cls    (r_cls),
    .r_mant   (r_mant),
    .r_sticky (r_sticky),
    .flag_nv  (flag_nv),
    .flag_dz  (flag_dz)
);

// File: tb/fdiv_unit_bench.sv
module fdiv_unit_bench;

    localparam int EW = 12;
    localparam int MW = 26;
    localparam logic [2:0] C_ZERO = 3'd0, C_NORM = 3'd1, C_INF = 3'd2,
                           C_QNAN = 3'd3, C_SNAN = 3'd4;

    typedef struct {
        logic [2:0]    cls;
        logic          sign;
        logic [EW-1:0] exp;
        logic [MW-1:0] mant;
        logic          sticky;
        logic          nv;
        logic          dz;
        longint        lat;
        longint        issue;
        string         tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    x_cls = '0, y_cls = '0;
    logic          x_sign = 1'b0, y_sign = 1'b0;
    logic [EW-1:0] x_exp = '0, y_exp = '0;
    logic [MW-1:0] x_mant = '0, y_mant = '0;
    logic          busy, done, r_sign, r_sticky, flag_nv, flag_dz;
    logic [2:0]    r_cls;
    logic [EW-1:0] r_exp;
    logic [MW-1:0] r_mant;

    int     checks = 0;
    int     errors = 0;
    longint cyc = 0;
    logic [31:0] seed = 32'h1234_5678;
    item_t  sbq[$];

    fdiv_unit #(.EXP_W(EW), .MANT_W(MW)) u_fdiv_unit (
        .clk(clk), .rst_n(rst_n), .start(start),
        .x_cls(x_cls), .x_sign(x_sign), .x_exp(x_exp), .x_mant(x_mant),
        .y_cls(y_cls), .y_sign(y_sign), .y_exp(y_exp), .y_mant(y_mant),
        .busy(busy), .done(done), .r_cls(r_cls), .r_sign(r_sign),
        .r_exp(r_exp), .r_mant(r_mant), .r_sticky(r_sticky),
        .flag_nv(flag_nv), .flag_dz(flag_dz)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    function automatic item_t model(logic [2:0] xc, logic xs, logic [EW-1:0] xe,
                                    logic [MW-1:0] xm, logic [2:0] yc, logic ys,
                                    logic [EW-1:0] ye, logic [MW-1:0] ym);
        item_t it;
        bit [63:0] num, q, r;
        bit xn, yn;
        xn = (xc == C_QNAN) || (xc == C_SNAN);
        yn = (yc == C_QNAN) || (yc == C_SNAN);
        it.sign = xs ^ ys; it.exp = '0; it.mant = '0; it.sticky = 1'b0;
        it.nv = 1'b0; it.dz = 1'b0; it.lat = 1;
        if (xn || yn) begin
            it.tag = "R6";
            if (yn && !(xc == C_SNAN && yc == C_QNAN)) begin
                it.cls = yc; it.sign = ys; it.exp = ye; it.mant = ym;
            end else begin
                it.cls = xc; it.sign = xs; it.exp = xe; it.mant = xm;
            end
        end else if ((xc == C_INF && yc == C_INF) || (xc == C_ZERO && yc == C_ZERO)) begin
            it.tag = "R7"; it.cls = C_QNAN; it.sign = 1'b0; it.mant = '1; it.nv = 1'b1;
        end else if (xc == C_INF || xc == C_ZERO) begin
            it.tag = "R8"; it.cls = xc;
        end else if (yc == C_INF) begin
            it.tag = "R8"; it.cls = C_ZERO;
        end else if (yc == C_ZERO) begin
            it.tag = "R9"; it.cls = C_INF; it.dz = 1'b1;
        end else begin
            it.tag = "R1"; it.cls = C_NORM; it.lat = MW + 1;
            if (xm >= ym) begin
                num = 64'(xm) << (MW - 1); it.exp = xe - ye;
            end else begin
                num = 64'(xm) << MW; it.exp = xe - ye - 1'b1;
            end
            q = num / 64'(ym); r = num % 64'(ym);
            it.mant = q[MW-1:0]; it.sticky = (r != 0);
        end
        return it;
    endfunction

    task automatic launch(logic [2:0] xc, logic xs, logic [EW-1:0] xe, logic [MW-1:0] xm,
                          logic [2:0] yc, logic ys, logic [EW-1:0] ye, logic [MW-1:0] ym);
        item_t it;
        it = model(xc, xs, xe, xm, yc, ys, ye, ym);
        it.issue = cyc;
        sbq.push_back(it);
        x_cls = xc; x_sign = xs; x_exp = xe; x_mant = xm;
        y_cls = yc; y_sign = ys; y_exp = ye; y_mant = ym;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic div_op(logic [2:0] xc, logic xs, logic [EW-1:0] xe, logic [MW-1:0] xm,
                          logic [2:0] yc, logic ys, logic [EW-1:0] ye, logic [MW-1:0] ym);
        launch(xc, xs, xe, xm, yc, ys, ye, ym);
        wait_done();
    endtask

    // monitor: compares each completion against the oldest expected item
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R11", "unexpected done", 1, 0);
            end else begin
                item_t e;
                bit nrm;
                e = sbq.pop_front();
                nrm = (e.tag == "R1");
                check(r_cls == e.cls, e.tag, "class", r_cls, e.cls);
                check(r_sign == e.sign, (nrm || e.tag == "R8" || e.tag == "R9") ? "R4" : e.tag,
                      "sign", r_sign, e.sign);
                check(r_exp == e.exp, nrm ? "R2" : e.tag, "exponent", r_exp, e.exp);
                check(r_mant == e.mant, e.tag, "mantissa", r_mant, e.mant);
                check(r_sticky == e.sticky, "R3", "sticky", r_sticky, e.sticky);
                check(flag_nv == e.nv, e.nv ? "R7" : "R12", "nv", flag_nv, e.nv);
                check(flag_dz == e.dz, e.dz ? "R9" : "R12", "dz", flag_dz, e.dz);
                check(cyc - e.issue == e.lat, nrm ? "R5" : "R10", "latency",
                      cyc - e.issue, e.lat);
            end
        end
        if (rst_n && !done) begin
            if (flag_nv || flag_dz) check(1'b0, "R12", "flag without done", 1, 0);
        end
    end

    localparam logic [MW-1:0] ONE  = MW'(1) << (MW - 1);
    localparam logic [MW-1:0] ONE5 = MW'(3) << (MW - 2);

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check(!busy && !done, "R5", "reset busy/done", {busy, done}, 0);
        check(!flag_nv && !flag_dz, "R12", "reset flags", {flag_nv, flag_dz}, 0);

        // R1 R2 R3 R4 directed normal patterns
        div_op(C_NORM, 0, 12'd5, ONE, C_NORM, 0, 12'd3, ONE);
        div_op(C_NORM, 1, 12'd0, ONE, C_NORM, 0, 12'd0, ONE5);
        div_op(C_NORM, 0, 12'hFF0, '1, C_NORM, 1, 12'd7, ONE);
        div_op(C_NORM, 1, 12'd9, ONE, C_NORM, 1, 12'hFFE, '1);
        div_op(C_NORM, 0, 12'd1, ONE5, C_NORM, 0, 12'd1, ONE5);
        div_op(C_NORM, 0, 12'd2, '1, C_NORM, 0, 12'd2, '1 - MW'(1));

        // random normal pairs
        for (int i = 0; i < 24; i++) begin
            logic [31:0] a, b, c;
            a = rnd(); b = rnd(); c = rnd();
            div_op(C_NORM, c[0], EW'(c[15:4]), {1'b1, a[MW-2:0]},
                   C_NORM, c[1], EW'(c[31:20]), {1'b1, b[MW-2:0]});
        end

        // full class matrix: R6 R7 R8 R9 R10
        for (int xc = 0; xc < 5; xc++) begin
            for (int yc = 0; yc < 5; yc++) begin
                logic [31:0] a, b;
                a = rnd(); b = rnd();
                div_op(3'(xc), a[0], EW'(a[11:1]), {1'b1, a[MW-1:1]},
                       3'(yc), b[0], EW'(b[11:1]), {1'b1, b[MW-1:1]});
                check(!busy, "R10", "busy after special", busy, 0);
            end
        end

        // R11: start while busy is ignored
        launch(C_NORM, 0, 12'd4, '1, C_NORM, 0, 12'd1, ONE5);
        repeat (4) @(negedge clk);
        x_cls = C_ZERO; y_cls = C_ZERO; x_mant = '0; y_mant = ONE;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy, "R11", "busy after ignored start", busy, 1);
        wait_done();
        repeat (MW + 4) @(negedge clk);
        check(sbq.size() == 0, "R11", "pending items", sbq.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R5 watchdog: actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule